// File: doc/BRIEF.md
# I2C-Controlled Channel Switch Controller

This block is the digital core of a two-way bus switch that is steered over I2C. It acts as a slave on an upstream bus and holds a single control byte. The two low bits of that byte choose which of two downstream channels are connected. The block raises one enable output per channel. The analog pass gates that those enables drive are outside the block.

SCL and SDA reach the block already oversampled by a system clock that runs at least eight times faster than SCL. The block drives SDA only through a pull-down enable, which models an open-drain output. A write stores a new channel selection, but the downstream enables change only when the master ends the transfer with STOP. A downstream channel is therefore never connected in the middle of a transfer.

Each channel has an active-low interrupt input. A read returns the state of both interrupt inputs as it is at the moment the byte is loaded for sending, together with the stored selection. A combined active-low interrupt output stays active while either input is low.

Top module: `chsw_ctrl`

## Requirements
- R1: The block acknowledges only the 7-bit address formed by the bits 1,1,1,0,0 followed by strap[1] and strap[0], sent most significant bit first. The eighth bit selects the direction: 1 is a read and 0 is a write. After any other address the block never pulls SDA low until the next START.
- R2: After an acknowledged write address, the block acknowledges every received byte. When a transfer carries several bytes, only the last one is kept. Only bits 1:0 of a written byte are stored, and its other bits are ignored.
- R3: Stored bit 0 enables chan_en[0] and stored bit 1 enables chan_en[1]. All four combinations are allowed, including none and both.
- R4: chan_en takes a newly written selection only after a STOP condition. Until then it keeps its previous value, including across a repeated START.
- R5: A read byte carries the stored bits 1:0 in bits 1:0. Bit 4 is 1 when irq_n[0] is low and bit 5 is 1 when irq_n[1] is low. Bits 7, 6, 3 and 2 are 0. The interrupt bits are captured when the byte is loaded for sending.
- R6: irq_out_n is low whenever either irq_n input is low, whatever the channel selection.
- R7: While rst_n is low, sampled on the clock, the stored selection and chan_en are cleared to 0, SDA is released and the bus engine returns to idle.
- R8: During a read, a master acknowledge makes the block send another byte with freshly captured interrupt bits. A master non-acknowledge makes the block release SDA so that the master can issue STOP.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START at any point restarts address reception. sda_pull changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Upstream SCL level, asynchronous |
| sda_in | input | 1 | Upstream SDA level as seen on the wire, asynchronous |
| strap | input | 2 | Address strap inputs; bit 1 is the higher address bit |
| irq_n | input | 2 | Active-low interrupt inputs, one per channel |
| sda_pull | output | 1 | When 1, the SDA line is pulled low |
| chan_en | output | 2 | Downstream channel enables |
| irq_out_n | output | 1 | Combined active-low interrupt output |

## Verification
The bench sends every one of the 128 seven-bit addresses with the straps fixed. This separates an exact match from addresses that differ in only one strap bit or one fixed bit, and it shows that a mismatch leaves SDA untouched. A series of written bytes with varied upper bits covers all four channel combinations. Each is checked before and after STOP, which shows that the selection waits for STOP and that the upper bits are discarded. Reads are made under all four interrupt input patterns, and the interrupt inputs change between two bytes of one read, which shows that the interrupt bits are captured when each byte is loaded. The bench also covers multi-byte writes, an address cut short by a repeated START, a read of a selection that is still pending, and a reset in the middle of a transfer.

// File: rtl/chsw_pkg.sv
// Shared types for the channel switch controller.
// Assumes: one byte per bus transfer unit, eight bits per byte.
package chsw_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,   // bus free or after STOP
        ST_ADDR,   // shifting in the address byte
        ST_AACK,   // acknowledging a matched address
        ST_WDAT,   // shifting in a written byte
        ST_WACK,   // acknowledging a written byte
        ST_RDAT,   // shifting out a read byte
        ST_RACK,   // sampling the master acknowledge
        ST_SKIP    // not addressed, or read ended; wait for START/STOP
    } bus_st_t;
endpackage

// File: rtl/chsw_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous level inputs.
// Assumes: each bit is a slow level signal; the bits are not related to each other.
module chsw_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the raw inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[0] <= RST_VAL;
                else        pipe[0] <= d;
            end
        end else begin : g_next
            // Later stages: pass on the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/chsw_cond.sv
// Bus condition detector: finds START, STOP and the SCL edges in the
// synchronized SCL/SDA levels.
// Assumes: the inputs are already synchronized to clk.
module chsw_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start,
    output logic stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q, sda_q;

    // Hold the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign start    = scl_s & scl_q & sda_q & ~sda_s;
    assign stop     = scl_s & scl_q & ~sda_q & sda_s;
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
endmodule

// File: rtl/chsw_fsm.sv
// Slave bus engine: receives and matches the address, acknowledges bytes,
// hands written bytes to the register and shifts read bytes out.
// Assumes: the bus conditions come from chan_cond. SDA is changed only after
// a detected SCL fall, so it is never changed while SCL is high.
module chsw_fsm
    import chsw_pkg::*;
#(
    parameter int STRAP_W = 2,
    parameter logic [6-STRAP_W:0] ADDR_HI = 5'b11100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               stop,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               scl_s,
    input  logic               sda_s,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rd_byte,
    output logic               sda_pull,
    output logic               wr_stb,
    output logic [BYTE_W-1:0]  wr_byte
);
    bus_st_t              st;
    logic [BYTE_W-1:0]    sh;
    logic [BIT_CNT_W-1:0] cnt;
    logic                 rw;
    logic                 phase;   // ack driven / last read bit seen
    logic                 more;    // master acknowledged a read byte
    logic [BYTE_W-1:0]    in_byte;

    assign in_byte = {sh[BYTE_W-2:0], sda_s};

    // Main bus state machine. START and STOP take priority over bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            sh       <= '0;
            cnt      <= '0;
            rw       <= 1'b0;
            phase    <= 1'b0;
            more     <= 1'b0;
            sda_pull <= 1'b0;
            wr_stb   <= 1'b0;
            wr_byte  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start) begin
                st       <= ST_ADDR;
                cnt      <= '0;
                phase    <= 1'b0;
                more     <= 1'b0;
                sda_pull <= 1'b0;
            end else if (stop) begin
                st       <= ST_IDLE;
                phase    <= 1'b0;
                more     <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR: if (scl_rise) begin
                        sh  <= in_byte;
                        cnt <= cnt + 1'b1;
                        if (cnt == 3'd7) begin
                            if (in_byte[BYTE_W-1:1] == {ADDR_HI, strap}) begin
                                rw <= in_byte[0];
                                st <= ST_AACK;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_AACK, ST_WACK: if (scl_fall) begin
                        if (!phase) begin
                            sda_pull <= 1'b1;
                            phase    <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            cnt   <= '0;
                            if (st == ST_AACK && rw) begin
                                sh       <= rd_byte;
                                sda_pull <= ~rd_byte[BYTE_W-1];
                                st       <= ST_RDAT;
                            end else begin
                                sda_pull <= 1'b0;
                                st       <= ST_WDAT;
                            end
                        end
                    end
                    ST_WDAT: if (scl_rise) begin
                        sh  <= in_byte;
                        cnt <= cnt + 1'b1;
                        if (cnt == 3'd7) begin
                            wr_stb  <= 1'b1;
                            wr_byte <= in_byte;
                            st      <= ST_WACK;
                        end
                    end
                    ST_RDAT: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == 3'd7) phase <= 1'b1;
                        end else if (scl_fall) begin
                            if (phase) begin
                                phase    <= 1'b0;
                                sda_pull <= 1'b0;
                                st       <= ST_RACK;
                            end else begin
                                sh       <= {sh[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            if (!sda_s) more <= 1'b1;
                            else        st   <= ST_SKIP;
                        end else if (scl_fall && more) begin
                            more     <= 1'b0;
                            cnt      <= '0;
                            sh       <= rd_byte;
                            sda_pull <= ~rd_byte[BYTE_W-1];
                            st       <= ST_RDAT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s);                                  // R9
    AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP || st == ST_IDLE) |-> !sda_pull);                 // R1
endmodule

// File: rtl/chsw_regs.sv
// Control register: holds the written selection and applies it to the
// channel enables when the bus shows STOP.
// Assumes: a write strobe and a STOP never fall in the same cycle.
module chsw_regs #(
    parameter int NCH = 2,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              stop,
    output logic [NCH-1:0]    sel,
    output logic [NCH-1:0]    chan_en
);
    // Store the low bits of each written byte; copy them to the enables at STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel     <= '0;
            chan_en <= '0;
        end else begin
            if (wr_stb) sel <= wr_byte[NCH-1:0];
            if (stop)   chan_en <= sel;
        end
    end

    AST_CHAN_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_en) |-> $past(stop));                              // R4
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (chan_en == '0 && sel == '0));                        // R7
endmodule

// File: rtl/chsw_ctrl.sv
// Top of the channel switch controller: synchronizes the bus and interrupt
// inputs, runs the slave engine, holds the control register, builds the read
// byte and combines the interrupts.
// Assumes: clk runs at least eight times the SCL rate.
module chsw_ctrl
    import chsw_pkg::*;
#(
    parameter int NCH = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_in,
    input  logic           sda_in,
    input  logic [1:0]     strap,
    input  logic [NCH-1:0] irq_n,
    output logic           sda_pull,
    output logic [NCH-1:0] chan_en,
    output logic           irq_out_n
);
    localparam int IRQ_BASE = 4;
    localparam int SW = NCH + 2;

    logic [SW-1:0]     sync_q;
    logic              scl_s, sda_s;
    logic [NCH-1:0]    irq_s;
    logic              start, stop, scl_rise, scl_fall;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] rd_byte;
    logic [NCH-1:0]    sel;

    chsw_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({irq_n, sda_in, scl_in}),
        .q(sync_q)
    );
    assign scl_s = sync_q[0];
    assign sda_s = sync_q[1];
    assign irq_s = sync_q[SW-1:2];

    chsw_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start(start), .stop(stop), .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    chsw_fsm #(.STRAP_W(2), .ADDR_HI(5'b11100)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .scl_s(scl_s), .sda_s(sda_s),
        .strap(strap), .rd_byte(rd_byte), .sda_pull(sda_pull),
        .wr_stb(wr_stb), .wr_byte(wr_byte)
    );

    chsw_regs #(.NCH(NCH), .BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .stop(stop), .sel(sel), .chan_en(chan_en)
    );

    // Assemble the read byte: selection bits low, interrupt flags from bit 4.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NCH; i++) begin
            rd_byte[i]            = sel[i];
            rd_byte[IRQ_BASE + i] = ~irq_s[i];
        end
    end

    assign irq_out_n = &irq_s;
endmodule

// File: tb/sim_chsw_ctrl.sv
module sim_chsw_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic [1:0] irq_n = 2'b11;
    logic       sda_pull;
    logic [1:0] chan_en;
    logic       irq_out_n;
    wire        sda_line = sda_m & ~sda_pull;
    int         n_chk = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    chsw_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .strap(strap), .irq_n(irq_n), .sda_pull(sda_pull),
        .chan_en(chan_en), .irq_out_n(irq_out_n)
    );

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl) begin
            sda_m = 1'b1; cyc(4); scl = 1'b1; cyc(8);
        end
        sda_m = 1'b0; cyc(8); scl = 1'b0; cyc(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; cyc(4); scl = 1'b1; cyc(8); sda_m = 1'b1; cyc(16);
    endtask

    task automatic put_bit(input logic b);
        cyc(4); sda_m = b; cyc(4); scl = 1'b1; cyc(8); scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; cyc(8); scl = 1'b1; cyc(4); b = sda_line; cyc(4); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic m_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~m_ack);
    endtask

    function automatic logic [6:0] own_addr(input logic [1:0] s);
        return {5'b11100, s};
    endfunction

    // Full write transfer with a STOP at the end.
    task automatic write_reg(input logic [7:0] v);
        logic a;
        bus_start(); send_byte({own_addr(strap), 1'b0}, a); send_byte(v, a); bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic       a, a2;
        logic [7:0] rv, rv2, d;
        logic [1:0] prev;
        cyc(5);
        // R7: state during reset.
        chk(chan_en == 2'b00, "R7 reset chan", {6'd0, chan_en}, 8'h00);
        chk(sda_pull == 1'b0, "R7 reset sda", {7'd0, sda_pull}, 8'h00);
        rst_n = 1'b1; cyc(5);
        chk(irq_out_n == 1'b1, "R6 idle irq_out", {7'd0, irq_out_n}, 8'h01);

        // R1: sweep all addresses with strap=10, write direction.
        for (int ad = 0; ad < 128; ad++) begin
            logic exp_ack;
            exp_ack = (ad[6:0] == own_addr(strap));
            bus_start(); send_byte({ad[6:0], 1'b0}, a); bus_stop();
            chk(a == exp_ack, "R1 address ack", {7'd0, a}, {7'd0, exp_ack});
        end

        // R1: mismatched address followed by data: no ack, no effect.
        bus_start(); send_byte({7'h73, 1'b0}, a); send_byte(8'h03, a2); bus_stop();
        chk(a2 == 1'b0, "R1 data after mismatch", {7'd0, a2}, 8'h00);
        chk(chan_en == 2'b00, "R1 mismatch chan", {6'd0, chan_en}, 8'h00);

        // R1/R3: each strap value, matching and neighbouring addresses.
        for (int s = 0; s < 4; s++) begin
            strap = s[1:0]; cyc(4);
            bus_start(); send_byte({own_addr(s[1:0] + 2'd1), 1'b0}, a); bus_stop();
            chk(a == 1'b0, "R1 other strap", {7'd0, a}, 8'h00);
            write_reg({6'h2A, ~s[1:0]});
            chk(chan_en == ~s[1:0], "R3 strap write", {6'd0, chan_en}, {6'd0, ~s[1:0]});
        end
        strap = 2'b10; cyc(4);

        // R2/R3/R4/R5: write sweep, check pending then applied, then read back.
        for (int i = 0; i < 16; i++) begin
            d = 8'(i * 37) ^ 8'h5C;
            prev = chan_en;
            bus_start(); send_byte({own_addr(strap), 1'b0}, a); send_byte(d, a2);
            chk(a2 == 1'b1, "R2 data ack", {7'd0, a2}, 8'h01);
            cyc(20);
            chk(chan_en == prev, "R4 held before stop", {6'd0, chan_en}, {6'd0, prev});
            bus_stop();
            chk(chan_en == d[1:0], "R3 applied after stop", {6'd0, chan_en}, {6'd0, d[1:0]});
            bus_start(); send_byte({own_addr(strap), 1'b1}, a); recv_byte(rv, 1'b0); bus_stop();
            chk(rv == {6'd0, d[1:0]}, "R2 R5 readback", rv, {6'd0, d[1:0]});
        end

        // R2: several bytes in one transfer, last kept.
        bus_start(); send_byte({own_addr(strap), 1'b0}, a);
        send_byte(8'hF1, a2); send_byte(8'h06, a2); bus_stop();
        chk(chan_en == 2'b10, "R2 last byte kept", {6'd0, chan_en}, 8'h02);

        // R5/R6: all interrupt patterns.
        for (int q = 0; q < 4; q++) begin
            irq_n = q[1:0]; cyc(6);
            chk(irq_out_n == &q[1:0], "R6 combined irq", {7'd0, irq_out_n}, {7'd0, &q[1:0]});
            bus_start(); send_byte({own_addr(strap), 1'b1}, a); recv_byte(rv, 1'b0); bus_stop();
            chk(rv == {2'b00, ~q[1:0], 4'b0010}, "R5 read irq bits", rv, {2'b00, ~q[1:0], 4'b0010});
        end

        // R8: master ack gives a second byte with fresh interrupt state; nack releases.
        irq_n = 2'b11; cyc(4);
        bus_start(); send_byte({own_addr(strap), 1'b1}, a);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b); rv[i] = b;
        end
        irq_n = 2'b10;
        put_bit(1'b0);
        recv_byte(rv2, 1'b0);
        cyc(6);
        chk(sda_pull == 1'b0, "R8 released after nack", {7'd0, sda_pull}, 8'h00);
        bus_stop();
        chk(rv == 8'h02, "R8 first byte", rv, 8'h02);
        chk(rv2 == 8'h12, "R8 second byte fresh", rv2, 8'h12);
        irq_n = 2'b11;

        // R9: address cut by a repeated START, then a full write.
        bus_start(); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start(); send_byte({own_addr(strap), 1'b0}, a); send_byte(8'h01, a2); bus_stop();
        chk(a == 1'b1 && chan_en == 2'b01, "R9 repeated start", {6'd0, chan_en}, 8'h01);

        // R4: pending write read back via repeated START, enables unchanged.
        bus_start(); send_byte({own_addr(strap), 1'b0}, a); send_byte(8'h03, a2);
        bus_start(); send_byte({own_addr(strap), 1'b1}, a); recv_byte(rv, 1'b0);
        chk(chan_en == 2'b01, "R4 held across restart", {6'd0, chan_en}, 8'h01);
        bus_stop();
        chk(rv == 8'h03, "R4 pending readback", rv, 8'h03);
        chk(chan_en == 2'b11, "R4 applied at stop", {6'd0, chan_en}, 8'h03);

        // R7: reset in the middle of a transfer.
        bus_start(); send_byte({own_addr(strap), 1'b0}, a); put_bit(1'b0); put_bit(1'b1);
        rst_n = 1'b0; cyc(3);
        chk(chan_en == 2'b00 && sda_pull == 1'b0, "R7 mid reset", {6'd0, chan_en}, 8'h00);
        rst_n = 1'b1; cyc(3);
        bus_stop();
        bus_start(); send_byte({own_addr(strap), 1'b1}, a); recv_byte(rv, 1'b0); bus_stop();
        chk(rv == 8'h00, "R7 register cleared", rv, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule